// File: doc/BRIEF.md
# PCIe Root Port Event Interrupt Controller

This block collects the event sources of a PCIe root-port bridge into one 32-bit pending register and one 32-bit enable register, and raises a single interrupt line when any pending event is also enabled. Each event input sets its pending bit on every clock cycle in which it is high. A one-cycle pulse is therefore captured and held. A source that stays high keeps its bit set, which gives level-type behaviour. Software reads both registers over a small word-addressed register port. It acknowledges events by writing ones to the pending register, and it enables or disables them by rewriting the enable register.

The physical bit layout is as follows. Bits 0-7 are DMA completion events. Bits 8-15 are DMA error events. Bits 16-23 are the bridge's AXI-side and PCIe-side post, fetch and discard errors and doorbells. Bits 24-27 are the four INTx lines. Bits 28-31 are MSI, AER, power-management/LTR/hotplug and system error.

Software names events by a logical number from 0 to 28. In that numbering the four INTx bits form a single event, and every event above it is moved up by three bit positions. A combinational helper port converts a logical event number into its physical bit mask, so that driver-side mask arithmetic can be reproduced and checked.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset the pending register, the enable register and `irq_out` are all zero.
- R2: An event input that is high during a rising clock edge sets the matching pending bit at that edge. The bit stays set after the input drops, until it is acknowledged.
- R3: A write to address 0 (pending register) clears exactly the pending bits whose write-data bit is 1. All other pending bits keep their value.
- R4: If an event input is high at the same edge as an acknowledge of its bit, the bit stays set. A source that is still active therefore re-asserts after acknowledge.
- R5: A write to address 1 (enable register) loads the write data. A 1 enables the event at that bit position and a 0 masks it.
- R6: `irq_out` is registered. It is 1 in the cycle after an edge where the pending register ANDed with the enable register is nonzero, and 0 otherwise.
- R7: The helper mask for logical events 0 to 23 has the single bit at the same position set.
- R8: The helper mask for logical event 24 (INTx group) is 32'h0F00_0000, covering bits 24 to 27.
- R9: The helper mask for logical events 25 to 28 has the single bit at position event+3 set, which is bits 28 to 31.
- R10: The helper mask for logical numbers 29 to 31 is zero.
- R11: Reads return the pending register at address 0, the enable register at address 1 and zero at addresses 2 and 3. Writes to addresses 2 and 3 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 32 | Event sources, one per physical bit |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word address: 0 pending, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Combined, registered interrupt request |
| map_evt | input | 5 | Logical event number for the helper |
| map_mask | output | 32 | Physical bit mask of `map_evt` |

## Verification
Single-cycle pulses on the DMA and INTx bits show that events are captured and held rather than passed through. A source held high across an acknowledge shows that a set wins over a clear, and dropping the same source shows that the acknowledge still works. Acknowledge writes that hit only part of the pending bits show that exactly the written ones clear. Enable values that do and do not overlap the pending bits show that the interrupt follows the masked status one cycle later. A sweep of all 32 helper inputs covers the one-to-one range, the INTx group, the shifted range and the unused codes separately.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NUM_BITS  = 32;
    localparam int NUM_EVT   = 29;
    localparam int EVT_W     = 5;
    localparam int ADDR_W    = 2;
    localparam int INTX_BASE = 24;
    localparam int INTX_W    = 4;
    localparam int INTX_EVT  = INTX_BASE;
    localparam int SHIFT_UP  = INTX_W - 1;

    typedef logic [NUM_BITS-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND  = 2'd0,
        REG_ENAB  = 2'd1,
        REG_SPARE = 2'd2,
        REG_TAIL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       wr;
        reg_sel_e   sel;
        word_t      data;
    } bus_req_t;

    function automatic word_t evt_to_mask(input logic [EVT_W-1:0] n);
        word_t one;
        word_t grp;
        one = word_t'(1);
        grp = word_t'({INTX_W{1'b1}}) << INTX_BASE;
        if (n < EVT_W'(INTX_EVT))
            return one << n;
        else if (n == EVT_W'(INTX_EVT))
            return grp;
        else if (n < EVT_W'(NUM_EVT))
            return one << ({1'b0, n} + (EVT_W+1)'(SHIFT_UP));
        else
            return '0;
    endfunction

endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank
    import evt_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t evt_in,
    input  logic  ack_en,
    input  word_t ack_bits,
    output word_t pend_q
);

    word_t pend_d;

    generate
        for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
            always_comb begin
                pend_d[i] = pend_q[i];
                if (ack_en && ack_bits[i])
                    pend_d[i] = 1'b0;
                if (evt_in[i])
                    pend_d[i] = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

endmodule

// File: rtl/evt_enab_reg.sv
module evt_enab_reg
    import evt_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_val,
    output word_t enab_q
);

    always_ff @(posedge clk) begin
        if (rst)
            enab_q <= '0;
        else if (load)
            enab_q <= load_val;
    end

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
    import evt_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t pend,
    input  word_t enab,
    output logic  irq_q
);

    word_t live;

    always_comb live = pend & enab;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |live;
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BITS-1:0]  evt_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_BITS-1:0]  bus_wdata,
    output logic [NUM_BITS-1:0]  bus_rdata,
    output logic                 irq_out,
    input  logic [EVT_W-1:0]     map_evt,
    output logic [NUM_BITS-1:0]  map_mask
);

    bus_req_t req;
    word_t    status_q;
    word_t    mask_q;
    logic     wr_pend;
    logic     wr_enab;

    always_comb begin
        req.wr   = bus_wr;
        req.sel  = reg_sel_e'(bus_addr);
        req.data = bus_wdata;
        wr_pend  = req.wr && (req.sel == REG_PEND);
        wr_enab  = req.wr && (req.sel == REG_ENAB);
    end

    evt_pend_bank u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (evt_in),
        .ack_en   (wr_pend),
        .ack_bits (req.data),
        .pend_q   (status_q)
    );

    evt_enab_reg u_enab (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_enab),
        .load_val (req.data),
        .enab_q   (mask_q)
    );

    evt_irq_merge u_merge (
        .clk   (clk),
        .rst   (rst),
        .pend  (status_q),
        .enab  (mask_q),
        .irq_q (irq_out)
    );

    always_comb begin
        case (req.sel)
            REG_PEND: bus_rdata = status_q;
            REG_ENAB: bus_rdata = mask_q;
            default:  bus_rdata = '0;
        endcase
    end

    always_comb map_mask = evt_to_mask(map_evt);

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_BITS-1:0] evt_in,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_BITS-1:0] bus_wdata,
    input logic [NUM_BITS-1:0] status_q,
    input logic [NUM_BITS-1:0] mask_q,
    input logic                irq_out,
    input logic [EVT_W-1:0]    map_evt,
    input logic [NUM_BITS-1:0] map_mask
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_q == '0 && mask_q == '0 && !irq_out));

    assert_event_held_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0)
            |=> ((status_q & $past(bus_wdata & ~evt_in)) == '0));

    assert_enab_load_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> (mask_q == $past(bus_wdata)));

    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == ($past(status_q & mask_q) != '0)));

    assert_spare_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[1]) |=> $stable(mask_q));

    always_comb begin
        if (map_evt < 5'd24)
            assert_low_onehot_R7: assert ($countones(map_mask) == 1);
        if (map_evt > 5'd28)
            assert_unused_zero_R10: assert (map_mask == '0);
    end

endmodule

bind evt_irq_ctrl evt_irq_chk u_chk (.*);

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_in = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [4:0]  map_evt = 5'd0;
    logic [31:0] map_mask;

    int n_checks = 0;
    int n_fail = 0;

    evt_irq_ctrl dut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .map_evt(map_evt), .map_mask(map_mask)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [31:0] ev);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_in = ev;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0; bus_addr = 2'd0;
    endtask

    task automatic pulse(input logic [31:0] ev);
        evt_in = ev;
        @(posedge clk);
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 pending", v, 32'h0);
        rd(2'd1, v); check("R1 enable", v, 32'h0);
        check("R1 irq", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_mapping();
        for (int e = 0; e < 32; e++) begin
            logic [31:0] exp;
            string tag;
            if (e < 24) begin exp = 32'h1 << e; tag = "R7 map"; end
            else if (e == 24) begin exp = 32'h0F00_0000; tag = "R8 map"; end
            else if (e < 29) begin exp = 32'h1 << (e + 3); tag = "R9 map"; end
            else begin exp = 32'h0; tag = "R10 map"; end
            map_evt = 5'(e);
            #1;
            check(tag, map_mask, exp);
        end
    endtask

    task automatic t_pulse_capture();
        logic [31:0] v;
        pulse(32'h0000_0020);
        tick();
        rd(2'd0, v); check("R2 pulse held", v, 32'h0000_0020);
        check("R6 masked no irq", {31'd0, irq_out}, 32'h0);
        pulse(32'h0F00_0000);
        rd(2'd0, v); check("R2 intx held", v, 32'h0F00_0020);
    endtask

    task automatic t_enable_irq();
        logic [31:0] v;
        wr(2'd1, 32'h0000_0100, 32'h0);
        rd(2'd1, v); check("R5 enable readback", v, 32'h0000_0100);
        tick();
        check("R6 no overlap no irq", {31'd0, irq_out}, 32'h0);
        wr(2'd1, 32'h0000_0020, 32'h0);
        check("R6 irq not yet", {31'd0, irq_out}, 32'h0);
        tick();
        check("R6 irq raised", {31'd0, irq_out}, 32'h1);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0020, 32'h0);
        rd(2'd0, v); check("R3 partial ack", v, 32'h0F00_0000);
        rd(2'd1, v); check("R3 enable untouched", v, 32'h0000_0020);
        tick();
        check("R6 irq dropped", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(2'd0, 32'h1000_0000, 32'h1000_0000);
        rd(2'd0, v); check("R4 set wins", v, 32'h1F00_0000);
        wr(2'd0, 32'h1F00_0000, 32'h0);
        rd(2'd0, v); check("R4 ack after release", v, 32'h0);
    endtask

    task automatic t_spare();
        logic [31:0] v;
        pulse(32'h0000_8000);
        wr(2'd2, 32'hFFFF_FFFF, 32'h0);
        wr(2'd3, 32'h0000_0000, 32'h0);
        rd(2'd2, v); check("R11 addr2 reads zero", v, 32'h0);
        rd(2'd3, v); check("R11 addr3 reads zero", v, 32'h0);
        rd(2'd0, v); check("R11 pending unchanged", v, 32'h0000_8000);
        rd(2'd1, v); check("R11 enable unchanged", v, 32'h0000_0020);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mapping();
        t_pulse_capture();
        t_enable_irq();
        t_ack();
        t_priority();
        t_spare();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule